// File: doc/BRIEF.md
# Address Window Decoder With Remap

This block sits between a CPU address bus and a set of target ports. Eight windows are programmed by software. Each window holds an enable, a size mask, a target number, an attribute and a base. A few low-numbered windows also hold a remap pair. The block compares every looked-up address against all windows at once. It picks the lowest-numbered window that matches and returns that window's target, attribute and translated address one clock later.

Window size is set by a thermometer field. It is a run of ones that starts at bit 0 of the field, and each one doubles the window, from a floor of 64 KiB. Windows with remap replace the address bits above the window size with the remap-low value, and take the upper half of a double-width address from remap-high. Windows without remap pass the address through unchanged, zero-extended.

Software writes one 32-bit register at a time through a simple write port. It can read any register back through a combinational read port. The read port is the normal way to confirm what a window holds.

Top module: `addr_win_decoder`

## Requirements
- R1: There are eight windows, and each is programmed independently. After reset every control register is zero, so every lookup misses.
- R2: A window matches when its enable is set and the address and the base agree on every bit that is not in the mask. The mask is the size field placed on bits 31:16 with bits 15:0 all ones. A size field of 0x0000 covers 64 KiB and 0x00FF covers 16 MiB. Address bits 15:0 always reach the result unchanged on a hit.
- R3: The control register fields are: enable on bit 0, target number on bits 4:1, attribute on bits 15:5, size on bits 31:16. All 32 bits read back as written.
- R4: Writing zero to a control register disables that window whatever its base holds, and the base keeps its value.
- R5: When several enabled windows match, the result reports the lowest-numbered one, with that window's target and attribute.
- R6: Windows 0 and 1 remap on a hit. Result bits 31:0 take the address inside the mask and remap-low outside it. Result bits 63:32 equal remap-high.
- R7: On a remap window whose remap-low equals its base, result bits 31:0 equal the looked-up address.
- R8: Windows 2 to 7 have no remap registers. A hit on them returns the address zero-extended to 64 bits. Writes with selector 2 or 3 to them are ignored, and those registers read back as zero.
- R9: Base and remap-low keep only bits 31:16, so bits 15:0 read back as zero. Remap-high keeps all 32 bits.
- R10: The result is registered: it reflects the address presented and the registers held in the cycle before. On a miss, hit is low, window, target and attribute are zero, and the result address is the looked-up address zero-extended.
- R11: Two windows programmed to the same range and target decode correctly. When the lower of the two is disabled, the other one answers.
- R12: Register selector encoding on the write and read ports: 0 is control, 1 is base, 2 is remap-low, 3 is remap-high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index for the write |
| wr_sel | input | 2 | Register selector for the write (R12) |
| wr_data | input | 32 | Write data |
| rd_win | input | 3 | Window index for readback |
| rd_sel | input | 2 | Register selector for readback (R12) |
| rd_data | output | 32 | Readback data, combinational |
| lk_addr | input | 32 | Address to look up |
| res_hit | output | 1 | Some enabled window matched |
| res_win | output | 3 | Index of the winning window |
| res_tgt | output | 4 | Target number of the winning window |
| res_attr | output | 11 | Attribute of the winning window |
| res_addr | output | 64 | Translated address |

## Verification
A corrupted size or base register changes which addresses match. It shows up on the first lookup that falls near a window edge, one clock after that address is presented, and also at once on the read port. A wrong priority choice or a stale remap value shows in res_win or in the upper result bits on the next overlapping lookup. The reference model is therefore compared on every clock, over lookups aimed at window boundaries and at ranges that overlap.

// File: rtl/awd_pkg.sv
package awd_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } awd_sel_e;

   // control word layout: enable, target, attribute, then size on the upper half
   localparam int EN_BIT  = 0;
   localparam int TGT_LSB = 1;
   localparam int GRAN    = 16;   // 64 KiB granule

endpackage

// File: rtl/awd_window.sv
module awd_window
   import awd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 4,
   parameter bit HAS_REMAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  awd_sel_e              wsel,
   input  logic [ADDR_W-1:0]     wdata,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  hit,
   output logic [TGT_W-1:0]      tgt,
   output logic [GRAN-1-TGT_W-1:0] attr,
   output logic [2*ADDR_W-1:0]   xlat,
   output logic [ADDR_W-1:0]     ctrl_word,
   output logic [ADDR_W-1:0]     base_word,
   output logic [ADDR_W-1:0]     rlo_word,
   output logic [ADDR_W-1:0]     rhi_word
);

   localparam int SZ_W     = ADDR_W - GRAN;
   localparam int ATTR_W   = GRAN - 1 - TGT_W;
   localparam int ATTR_LSB = TGT_LSB + TGT_W;

   logic              en_q;
   logic [SZ_W-1:0]   size_q;
   logic [SZ_W-1:0]   base_q;
   logic [TGT_W-1:0]  tgt_q;
   logic [ATTR_W-1:0] attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         size_q <= '0;
         base_q <= '0;
         tgt_q  <= '0;
         attr_q <= '0;
      end else if (we) begin
         case (wsel)
            SEL_CTRL: begin
               en_q   <= wdata[EN_BIT];
               tgt_q  <= wdata[TGT_LSB +: TGT_W];
               attr_q <= wdata[ATTR_LSB +: ATTR_W];
               size_q <= wdata[ADDR_W-1:GRAN];
            end
            SEL_BASE: base_q <= wdata[ADDR_W-1:GRAN];
            default: ;
         endcase
      end
   end

   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[EN_BIT]               = en_q;
      ctrl_word[TGT_LSB +: TGT_W]     = tgt_q;
      ctrl_word[ATTR_LSB +: ATTR_W]   = attr_q;
      ctrl_word[ADDR_W-1:GRAN]        = size_q;
   end

   assign base_word = {base_q, {GRAN{1'b0}}};
   assign hit  = en_q && (((addr[ADDR_W-1:GRAN] ^ base_q) & ~size_q) == '0);
   assign tgt  = tgt_q;
   assign attr = attr_q;

   generate
      if (HAS_REMAP) begin : g_remap
         logic [SZ_W-1:0]   rlo_q;
         logic [ADDR_W-1:0] rhi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rlo_q <= '0;
               rhi_q <= '0;
            end else if (we) begin
               if (wsel == SEL_RLO) rlo_q <= wdata[ADDR_W-1:GRAN];
               if (wsel == SEL_RHI) rhi_q <= wdata;
            end
         end
         assign xlat = {rhi_q,
                        (addr[ADDR_W-1:GRAN] & size_q) | (rlo_q & ~size_q),
                        addr[GRAN-1:0]};
         assign rlo_word = {rlo_q, {GRAN{1'b0}}};
         assign rhi_word = rhi_q;
      end else begin : g_plain
         assign xlat     = {{ADDR_W{1'b0}}, addr};
         assign rlo_word = '0;
         assign rhi_word = '0;
      end
   endgenerate

endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
   parameter int N      = 8,
   parameter int WIN_W  = 3,
   parameter int TGT_W  = 4,
   parameter int ATTR_W = 11,
   parameter int XW     = 64
) (
   input  logic [N-1:0]             hit_i,
   input  logic [N-1:0][TGT_W-1:0]  tgt_i,
   input  logic [N-1:0][ATTR_W-1:0] attr_i,
   input  logic [N-1:0][XW-1:0]     xlat_i,
   output logic                     any_o,
   output logic [WIN_W-1:0]         idx_o,
   output logic [TGT_W-1:0]         tgt_o,
   output logic [ATTR_W-1:0]        attr_o,
   output logic [XW-1:0]            xlat_o
);

   // ascending scan, first match claims the result
   always_comb begin
      any_o  = 1'b0;
      idx_o  = '0;
      tgt_o  = '0;
      attr_o = '0;
      xlat_o = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_i[i] && !any_o) begin
            any_o  = 1'b1;
            idx_o  = WIN_W'(i);
            tgt_o  = tgt_i[i];
            attr_o = attr_i[i];
            xlat_o = xlat_i[i];
         end
      end
   end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 4,
   localparam int WIN_W    = $clog2(NUM_WIN),
   localparam int ATTR_W   = GRAN - 1 - TGT_W,
   localparam int XW       = 2 * ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIN_W-1:0]  wr_win,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [WIN_W-1:0]  rd_win,
   input  logic [1:0]        rd_sel,
   output logic [ADDR_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              res_hit,
   output logic [WIN_W-1:0]  res_win,
   output logic [TGT_W-1:0]  res_tgt,
   output logic [ATTR_W-1:0] res_attr,
   output logic [XW-1:0]     res_addr
);

   generate
      if (NUM_WIN < 2)            begin : g_chk_n   $error("NUM_WIN must be at least 2");            end
      if (NUM_REMAP > NUM_WIN)    begin : g_chk_r   $error("NUM_REMAP exceeds NUM_WIN");            end
      if (ADDR_W <= GRAN)         begin : g_chk_a   $error("ADDR_W must exceed the granule width"); end
      if (TGT_W < 1 || TGT_W > GRAN - 2) begin : g_chk_t $error("TGT_W leaves no attribute bits"); end
   endgenerate

   logic [NUM_WIN-1:0]             w_hit;
   logic [NUM_WIN-1:0][TGT_W-1:0]  w_tgt;
   logic [NUM_WIN-1:0][ATTR_W-1:0] w_attr;
   logic [NUM_WIN-1:0][XW-1:0]     w_xlat;
   logic [NUM_WIN-1:0][ADDR_W-1:0] w_ctrl, w_base, w_rlo, w_rhi;

   genvar g;
   generate
      for (g = 0; g < NUM_WIN; g++) begin : g_win
         awd_window #(
            .ADDR_W    (ADDR_W),
            .TGT_W     (TGT_W),
            .HAS_REMAP (g < NUM_REMAP)
         ) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (wr_en && (wr_win == WIN_W'(g))),
            .wsel      (awd_sel_e'(wr_sel)),
            .wdata     (wr_data),
            .addr      (lk_addr),
            .hit       (w_hit[g]),
            .tgt       (w_tgt[g]),
            .attr      (w_attr[g]),
            .xlat      (w_xlat[g]),
            .ctrl_word (w_ctrl[g]),
            .base_word (w_base[g]),
            .rlo_word  (w_rlo[g]),
            .rhi_word  (w_rhi[g])
         );
      end
   endgenerate

   logic              any_hit;
   logic [WIN_W-1:0]  sel_idx;
   logic [TGT_W-1:0]  sel_tgt;
   logic [ATTR_W-1:0] sel_attr;
   logic [XW-1:0]     sel_xlat;

   awd_prio #(
      .N      (NUM_WIN),
      .WIN_W  (WIN_W),
      .TGT_W  (TGT_W),
      .ATTR_W (ATTR_W),
      .XW     (XW)
   ) u_prio (
      .hit_i  (w_hit),
      .tgt_i  (w_tgt),
      .attr_i (w_attr),
      .xlat_i (w_xlat),
      .any_o  (any_hit),
      .idx_o  (sel_idx),
      .tgt_o  (sel_tgt),
      .attr_o (sel_attr),
      .xlat_o (sel_xlat)
   );

   always_comb begin
      rd_data = '0;
      if (int'(rd_win) < NUM_WIN) begin
         case (awd_sel_e'(rd_sel))
            SEL_CTRL: rd_data = w_ctrl[rd_win];
            SEL_BASE: rd_data = w_base[rd_win];
            SEL_RLO:  rd_data = w_rlo[rd_win];
            default:  rd_data = w_rhi[rd_win];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit  <= 1'b0;
         res_win  <= '0;
         res_tgt  <= '0;
         res_attr <= '0;
         res_addr <= '0;
      end else begin
         res_hit  <= any_hit;
         res_win  <= sel_idx;
         res_tgt  <= sel_tgt;
         res_attr <= sel_attr;
         res_addr <= any_hit ? sel_xlat : {{ADDR_W{1'b0}}, lk_addr};
      end
   end

endmodule

// File: rtl/awd_checker.sv
module awd_checker
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 4,
   localparam int WIN_W    = $clog2(NUM_WIN),
   localparam int ATTR_W   = GRAN - 1 - TGT_W,
   localparam int XW       = 2 * ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rd_sel,
   input logic [ADDR_W-1:0] rd_data,
   input logic [ADDR_W-1:0] lk_addr,
   input logic              res_hit,
   input logic [WIN_W-1:0]  res_win,
   input logic [TGT_W-1:0]  res_tgt,
   input logic [ATTR_W-1:0] res_attr,
   input logic [XW-1:0]     res_addr
);

   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN) - 1);

   // R10: a miss carries no target, attribute or window
   p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_tgt == '0 && res_attr == '0 && res_win == '0));

   // R10: a miss returns the previous cycle's address, zero-extended
   p_miss_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !res_hit) |-> res_addr == {{ADDR_W{1'b0}}, $past(lk_addr)});

   // R2: the offset inside the granule survives any hit
   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && res_hit) |-> res_addr[GRAN-1:0] == $past(lk_addr[GRAN-1:0]));

   // R8: windows without remap return the address unchanged
   p_plain_ident_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && res_hit && int'(res_win) >= NUM_REMAP)
         |-> res_addr == {{ADDR_W{1'b0}}, $past(lk_addr)});

   // R9: base and remap-low never show low bits
   p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_BASE || rd_sel == SEL_RLO) |-> (rd_data & LOW_MASK) == '0);

endmodule

bind addr_win_decoder awd_checker #(
   .NUM_WIN   (NUM_WIN),
   .NUM_REMAP (NUM_REMAP),
   .ADDR_W    (ADDR_W),
   .TGT_W     (TGT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_sel   (rd_sel),
   .rd_data  (rd_data),
   .lk_addr  (lk_addr),
   .res_hit  (res_hit),
   .res_win  (res_win),
   .res_tgt  (res_tgt),
   .res_attr (res_attr),
   .res_addr (res_addr)
);

// File: tb/addr_win_decoder_tb.sv
module addr_win_decoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;
   localparam int NR = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_win = '0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_win = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [31:0] lk_addr = '0;
   logic        res_hit;
   logic [2:0]  res_win;
   logic [3:0]  res_tgt;
   logic [10:0] res_attr;
   logic [63:0] res_addr;

   addr_win_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data),
      .lk_addr(lk_addr), .res_hit(res_hit), .res_win(res_win), .res_tgt(res_tgt),
      .res_attr(res_attr), .res_addr(res_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural model state: readback images of each register
   logic [31:0] m_ctrl [NW];
   logic [31:0] m_base [NW];
   logic [31:0] m_rlo  [NW];
   logic [31:0] m_rhi  [NW];
   logic        e_hit;
   logic [2:0]  e_win;
   logic [3:0]  e_tgt;
   logic [10:0] e_attr;
   logic [63:0] e_addr;

   function automatic logic [31:0] mk_ctrl(logic [15:0] sz, logic [3:0] t, logic [10:0] a, logic en);
      return {sz, a, t, en};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NW; w++) begin
            m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
         end
         e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0; e_addr = 0;
      end else begin
         e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0; e_addr = {32'h0, lk_addr};
         for (int w = NW - 1; w >= 0; w--) begin
            logic [31:0] msk;
            msk = {m_ctrl[w][31:16], 16'hFFFF};
            if (m_ctrl[w][0] && (((lk_addr ^ m_base[w]) & ~msk) == 0)) begin
               e_hit = 1; e_win = 3'(w); e_tgt = m_ctrl[w][4:1]; e_attr = m_ctrl[w][15:5];
               e_addr = (w < NR) ? {m_rhi[w], (lk_addr & msk) | (m_rlo[w] & ~msk)}
                                 : {32'h0, lk_addr};
            end
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_ctrl[wr_win] = wr_data;
               2'd1: m_base[wr_win] = wr_data & 32'hFFFF_0000;
               2'd2: if (wr_win < NR) m_rlo[wr_win] = wr_data & 32'hFFFF_0000;
               default: if (wr_win < NR) m_rhi[wr_win] = wr_data;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(logic [2:0] w, logic [1:0] s);
      case (s)
         2'd0: return m_ctrl[w];
         2'd1: return m_base[w];
         2'd2: return m_rlo[w];
         default: return m_rhi[w];
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         n_cmp++;
         if ({res_hit, res_win, res_tgt, res_attr, res_addr} !== {e_hit, e_win, e_tgt, e_attr, e_addr}) begin
            n_bad++;
            $display("FAIL %s lookup: got hit=%0b win=%0d tgt=%0d attr=%h addr=%h, expected hit=%0b win=%0d tgt=%0d attr=%h addr=%h",
                     cur_req, res_hit, res_win, res_tgt, res_attr, res_addr,
                     e_hit, e_win, e_tgt, e_attr, e_addr);
         end
         n_cmp++;
         if (rd_data !== m_read(rd_win, rd_sel)) begin
            n_bad++;
            $display("FAIL %s readback win%0d sel%0d: got %h expected %h",
                     (rd_sel == 0) ? "R3" : ((rd_win >= NR && rd_sel >= 2) ? "R8" : "R9"),
                     rd_win, rd_sel, rd_data, m_read(rd_win, rd_sel));
         end
      end
   end

   task automatic wr(input int w, input int s, input logic [31:0] d);
      @(negedge clk); #1;
      wr_en = 1; wr_win = 3'(w); wr_sel = 2'(s); wr_data = d;
      @(negedge clk); #1;
      wr_en = 0;
   endtask

   task automatic look(input logic [31:0] a);
      @(negedge clk); #1;
      lk_addr = a;
      @(negedge clk);
   endtask

   task automatic expect_res(input string req, input logic h, input int w, input logic [63:0] a);
      n_cmp++;
      if (res_hit !== h || (h && res_win !== 3'(w)) || res_addr !== a) begin
         n_bad++;
         $display("FAIL %s direct: got hit=%0b win=%0d addr=%h, expected hit=%0b win=%0d addr=%h",
                  req, res_hit, res_win, res_addr, h, w, a);
      end
   endtask

   task automatic rd_expect(input string req, input int w, input int s, input logic [31:0] v);
      @(negedge clk); #1;
      rd_win = 3'(w); rd_sel = 2'(s);
      #1;
      n_cmp++;
      if (rd_data !== v) begin
         n_bad++;
         $display("FAIL %s read win%0d sel%0d: got %h expected %h", req, w, s, rd_data, v);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, everything misses
      cur_req = "R1";
      look(32'h0000_0000); expect_res("R1", 0, 0, 64'h0);
      look(32'hFFFF_FFFF); expect_res("R1", 0, 0, 64'h0000_0000_FFFF_FFFF);
      rd_expect("R1", 5, 0, 32'h0);

      // R3, R12, R2: smallest window
      cur_req = "R3";
      wr(4, 1, 32'h1234_0000);
      wr(4, 0, mk_ctrl(16'h0000, 4'd5, 11'h03C, 1'b1));
      rd_expect("R3", 4, 0, mk_ctrl(16'h0000, 4'd5, 11'h03C, 1'b1));
      cur_req = "R2";
      look(32'h1234_ABCD); expect_res("R2", 1, 4, 64'h0000_0000_1234_ABCD);
      n_cmp++;
      if (res_tgt !== 4'd5 || res_attr !== 11'h03C) begin
         n_bad++; $display("FAIL R3 fields: got tgt=%0d attr=%h expected tgt=5 attr=03c", res_tgt, res_attr);
      end
      look(32'h1235_0000); expect_res("R2", 0, 0, 64'h0000_0000_1235_0000);

      // R2: 16 MiB window edges
      wr(5, 1, 32'h2000_0000);
      wr(5, 0, mk_ctrl(16'h00FF, 4'd3, 11'h001, 1'b1));
      look(32'h20FF_FFFF); expect_res("R2", 1, 5, 64'h0000_0000_20FF_FFFF);
      look(32'h2100_0000); expect_res("R2", 0, 0, 64'h0000_0000_2100_0000);
      look(32'h1FFF_FFFF); expect_res("R2", 0, 0, 64'h0000_0000_1FFF_FFFF);

      // R6: remap on window 0
      cur_req = "R6";
      wr(0, 1, 32'h8000_0000);
      wr(0, 2, 32'h4000_0000);
      wr(0, 3, 32'h0000_0001);
      wr(0, 0, mk_ctrl(16'h0FFF, 4'd2, 11'h007, 1'b1));
      look(32'h8123_4567); expect_res("R6", 1, 0, 64'h0000_0001_4123_4567);

      // R7: identity remap on window 1
      cur_req = "R7";
      wr(1, 1, 32'h9000_0000);
      wr(1, 2, 32'h9000_0000);
      wr(1, 0, mk_ctrl(16'h000F, 4'd6, 11'h000, 1'b1));
      look(32'h900A_BCDE); expect_res("R7", 1, 1, 64'h0000_0000_900A_BCDE);

      // R5, R11: duplicate range on windows 6 and 7
      cur_req = "R5";
      wr(6, 1, 32'hF000_0000);
      wr(6, 0, mk_ctrl(16'h00FF, 4'd1, 11'h009, 1'b1));
      wr(7, 1, 32'hF000_0000);
      wr(7, 0, mk_ctrl(16'h00FF, 4'd1, 11'h009, 1'b1));
      look(32'hF012_3456); expect_res("R5", 1, 6, 64'h0000_0000_F012_3456);

      // R4, R11: disable lower then upper
      cur_req = "R4";
      wr(6, 0, 32'h0);
      look(32'hF012_3456); expect_res("R11", 1, 7, 64'h0000_0000_F012_3456);
      wr(7, 0, 32'h0);
      look(32'hF012_3456); expect_res("R4", 0, 0, 64'h0000_0000_F012_3456);
      rd_expect("R4", 7, 1, 32'hF000_0000);

      // R8: no remap registers on window 3
      cur_req = "R8";
      wr(3, 2, 32'hDEAD_BEEF);
      wr(3, 3, 32'hCAFE_F00D);
      rd_expect("R8", 3, 2, 32'h0);
      rd_expect("R8", 3, 3, 32'h0);
      wr(3, 1, 32'hA000_0000);
      wr(3, 0, mk_ctrl(16'h0000, 4'd4, 11'h010, 1'b1));
      look(32'hA000_1234); expect_res("R8", 1, 3, 64'h0000_0000_A000_1234);

      // R9: low bits dropped
      cur_req = "R9";
      wr(2, 1, 32'hABCD_FFFF);
      rd_expect("R9", 2, 1, 32'hABCD_0000);
      wr(0, 2, 32'h4000_1234);
      rd_expect("R9", 0, 2, 32'h4000_0000);
      rd_expect("R9", 0, 3, 32'h0000_0001);

      // R10: back-to-back lookups, one cycle each
      cur_req = "R10";
      look(32'h8000_0010); expect_res("R10", 1, 0, 64'h0000_0001_4000_0010);
      look(32'h0000_0042); expect_res("R10", 0, 0, 64'h0000_0000_0000_0042);

      // random traffic against the model (R2, R5, R6)
      cur_req = "R2";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk); #1;
         rd_win = 3'($urandom_range(0, 7));
         rd_sel = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 3))
            0: lk_addr = 32'h8000_0000 | ($urandom & 32'h1FFF_FFFF);
            1: lk_addr = 32'h2000_0000 | ($urandom & 32'h01FF_FFFF);
            2: lk_addr = 32'hF000_0000 | ($urandom & 32'h0FFF_FFFF);
            default: lk_addr = $urandom;
         endcase
         wr_en = 1'b0;
         if ($urandom_range(0, 15) == 0) begin
            int k;
            k = $urandom_range(0, 16);
            wr_en   = 1'b1;
            wr_win  = 3'($urandom_range(0, 7));
            wr_sel  = 2'($urandom_range(0, 3));
            wr_data = (wr_sel == 2'd0)
                      ? {16'(32'hFFFF >> k), 11'($urandom), 4'($urandom), 1'($urandom)}
                      : {4'hF, 4'($urandom), 24'($urandom)};
         end
      end
      @(negedge clk); #1 wr_en = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule